// File: doc/BRIEF.md
# Conditional Branch Direction Predictor with Full Flush

This block picks the fetch direction for a conditional branch at the moment it is fetched, before the flags it depends on exist. Three policies can be selected at run time: always fall through, always jump, or repeat whatever the last resolved branch actually did. The result drives a next-PC select to the fetch stage. The fetch stage chooses between the sequential address, the branch target, and a correction address from this block.

Later in the pipeline the branch resolves. The pipeline hands back the real outcome, the prediction that was made for that branch, its address and its target. If they disagree, the block raises a one-cycle flush that empties every pipeline register. On the same edge it loads the correction address, which is the target when the branch was taken and the fall-through address when it was not. A saturating counter records how many mispredicts have occurred.

Top module: `branch_flush_unit`

## Requirements
- R1: After reset, `flush_o` is 0, `miss_cnt_o` is 0, and the history holds "not taken", so the last-outcome mode predicts fall-through.
- R2: With `mode_i` = 0 (never taken) or 3 (reserved, same as 0), `nxt_sel_o` is never 1.
- R3: With `mode_i` = 1 (always taken), `nxt_sel_o` is 1 (target) whenever `fetch_vld_i` is high and `flush_o` is low.
- R4: With `mode_i` = 2 (last outcome), the prediction equals `res_taken_i` of the most recently accepted resolution. The history changes only on the clock edge that accepts a resolution, never on a fetch.
- R5: When `fetch_vld_i` is low and `flush_o` is low, `nxt_sel_o` is 0 (sequential).
- R6: An accepted resolution with `res_taken_i` != `res_pred_i` makes `flush_o` high for exactly the following cycle.
- R7: In a flush cycle, `redirect_pc_o` is `res_tgt_i` if the resolved branch was taken. Otherwise it is `res_pc_i` + STEP.
- R8: An accepted resolution with `res_taken_i` == `res_pred_i` raises no flush.
- R9: A resolution presented while `flush_o` is high belongs to a wrong-path instruction. It is ignored: no flush, no count and no history change.
- R10: `miss_cnt_o` increments by one per mispredict and saturates at 2^CNT_W-1.
- R11: While `flush_o` is high, `nxt_sel_o` is 2 (redirect), whatever the fetch inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 never taken, 1 always taken, 2 last outcome, 3 as 0 |
| fetch_vld_i | input | 1 | A conditional branch is being fetched this cycle |
| res_vld_i | input | 1 | A branch resolves this cycle |
| res_taken_i | input | 1 | Actual outcome of the resolving branch |
| res_pred_i | input | 1 | Direction that was predicted for the resolving branch |
| res_pc_i | input | PC_W | Address of the resolving branch |
| res_tgt_i | input | PC_W | Target of the resolving branch |
| nxt_sel_o | output | 2 | 0 sequential, 1 branch target, 2 redirect |
| redirect_pc_o | output | PC_W | Correction address, valid while flush_o is high |
| flush_o | output | 1 | Clear every pipeline register |
| miss_cnt_o | output | CNT_W | Saturating mispredict count |

## Verification
The bench builds the unit with CNT_W = 3, so the counter saturates after seven mispredicts. This lets the test reach the saturation corner and hold it past the limit in a few dozen cycles. PC_W stays at 16 and STEP at 1, which keeps the fall-through arithmetic easy to predict.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
    typedef enum logic [1:0] {
        PM_NEVER  = 2'd0,
        PM_ALWAYS = 2'd1,
        PM_LAST   = 2'd2,
        PM_RSVD   = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        SEL_SEQ = 2'd0,
        SEL_TGT = 2'd1,
        SEL_FIX = 2'd2
    } nsel_e;
endpackage

// File: rtl/bfu_dir.sv
module bfu_dir
    import bfu_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       hist_i,
    output logic       pred_o
);
    pmode_e mode;

    always_comb begin
        mode = pmode_e'(mode_i);
        unique case (mode)
            PM_ALWAYS: pred_o = 1'b1;
            PM_LAST:   pred_o = hist_i;
            default:   pred_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bfu_resolve.sv
module bfu_resolve #(
    parameter int PC_W = 16,
    parameter int STEP = 1
) (
    input  logic            vld_i,
    input  logic            block_i,
    input  logic            taken_i,
    input  logic            pred_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] tgt_i,
    output logic            accept_o,
    output logic            miss_o,
    output logic [PC_W-1:0] fix_pc_o
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    always_comb begin
        accept_o = vld_i && !block_i;
        miss_o   = accept_o && (taken_i != pred_i);
        fix_pc_o = taken_i ? tgt_i : (pc_i + STEP_V);
    end
endmodule

// File: rtl/bfu_sat_cnt.sv
module bfu_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != TOP)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/branch_flush_unit.sv
module branch_flush_unit
    import bfu_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int CNT_W = 8,
    parameter int STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             fetch_vld_i,
    input  logic             res_vld_i,
    input  logic             res_taken_i,
    input  logic             res_pred_i,
    input  logic [PC_W-1:0]  res_pc_i,
    input  logic [PC_W-1:0]  res_tgt_i,
    output logic [1:0]       nxt_sel_o,
    output logic [PC_W-1:0]  redirect_pc_o,
    output logic             flush_o,
    output logic [CNT_W-1:0] miss_cnt_o
);
    typedef struct packed {
        logic            hist;
        logic            flush;
        logic [PC_W-1:0] fix_pc;
    } state_t;

    state_t st_d, st_q;

    logic            pred;
    logic            accept;
    logic            miss;
    logic [PC_W-1:0] fix_pc;
    nsel_e           sel;

    bfu_dir i_dir (
        .mode_i (mode_i),
        .hist_i (st_q.hist),
        .pred_o (pred)
    );

    bfu_resolve #(.PC_W(PC_W), .STEP(STEP)) i_res (
        .vld_i    (res_vld_i),
        .block_i  (st_q.flush),
        .taken_i  (res_taken_i),
        .pred_i   (res_pred_i),
        .pc_i     (res_pc_i),
        .tgt_i    (res_tgt_i),
        .accept_o (accept),
        .miss_o   (miss),
        .fix_pc_o (fix_pc)
    );

    bfu_sat_cnt #(.W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (miss),
        .cnt_o (miss_cnt_o)
    );

    always_comb begin
        st_d = st_q;
        if (accept) st_d.hist = res_taken_i;
        st_d.flush = miss;
        if (miss) st_d.fix_pc = fix_pc;

        if (st_q.flush)                sel = SEL_FIX;
        else if (fetch_vld_i && pred)  sel = SEL_TGT;
        else                           sel = SEL_SEQ;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt_sel_o     = sel;
    assign redirect_pc_o = st_q.fix_pc;
    assign flush_o       = st_q.flush;
endmodule

// File: rtl/bfu_props.sv
module bfu_props #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 8,
    parameter int STEP  = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             fetch_vld_i,
    input logic             res_vld_i,
    input logic             res_taken_i,
    input logic             res_pred_i,
    input logic [PC_W-1:0]  res_pc_i,
    input logic [PC_W-1:0]  res_tgt_i,
    input logic [1:0]       nxt_sel_o,
    input logic [PC_W-1:0]  redirect_pc_o,
    input logic             flush_o,
    input logic [CNT_W-1:0] miss_cnt_o
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    p_flush_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(res_vld_i && !flush_o && (res_taken_i != res_pred_i)));

    p_redir_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (nxt_sel_o == 2'd2));

    p_never_tgt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 || mode_i == 2'd3) |-> (nxt_sel_o != 2'd1));

    p_fix_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (redirect_pc_o == $past(res_taken_i ? res_tgt_i : res_pc_i + PC_W'(STEP))));

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt_o != $past(miss_cnt_o)) |-> (miss_cnt_o == $past(miss_cnt_o) + 1'b1));

    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(miss_cnt_o) == CMAX) |-> (miss_cnt_o == CMAX));

    p_flush_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flush_o) && $past(miss_cnt_o) != CMAX) |-> (miss_cnt_o != $past(miss_cnt_o)));
endmodule

bind branch_flush_unit bfu_props #(.PC_W(PC_W), .CNT_W(CNT_W), .STEP(STEP)) i_props (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .fetch_vld_i   (fetch_vld_i),
    .res_vld_i     (res_vld_i),
    .res_taken_i   (res_taken_i),
    .res_pred_i    (res_pred_i),
    .res_pc_i      (res_pc_i),
    .res_tgt_i     (res_tgt_i),
    .nxt_sel_o     (nxt_sel_o),
    .redirect_pc_o (redirect_pc_o),
    .flush_o       (flush_o),
    .miss_cnt_o    (miss_cnt_o)
);

// File: tb/test_branch_flush_unit.sv
module test_branch_flush_unit;
    localparam int PC_W  = 16;
    localparam int CNT_W = 3;
    localparam int STEP  = 1;
    localparam logic [PC_W-1:0] BPC  = 16'h0040;
    localparam logic [PC_W-1:0] BTGT = 16'h0100;

    // {mode[1:0], fetch, res_vld, res_taken, res_pred, exp_sel[1:0], exp_flush_next}
    localparam int NV = 14;
    localparam logic [8:0] VEC [NV] = '{
        9'b00_1_0_0_0_00_0,   // R2 never
        9'b11_1_0_0_0_00_0,   // R2 reserved
        9'b01_1_0_0_0_01_0,   // R3 always
        9'b01_0_0_0_0_00_0,   // R5 no fetch
        9'b10_1_0_0_0_00_0,   // R4 history not taken
        9'b10_1_1_1_1_00_0,   // R8 correct, R4 still old history
        9'b10_1_0_0_0_01_0,   // R4 history now taken
        9'b10_1_1_0_1_01_1,   // R6 mispredict
        9'b10_1_1_1_0_10_0,   // R9 ignored during flush, R11
        9'b10_1_0_0_0_00_0,   // R9 history unchanged
        9'b01_1_1_0_1_01_1,   // R6 not-taken mispredict
        9'b01_1_0_0_0_10_0,   // R11
        9'b00_1_1_1_0_00_1,   // R6 taken mispredict
        9'b00_0_0_0_0_10_0    // R11
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       mode_i;
    logic             fetch_vld_i, res_vld_i, res_taken_i, res_pred_i;
    logic [PC_W-1:0]  res_pc_i, res_tgt_i;
    logic [1:0]       nxt_sel_o;
    logic [PC_W-1:0]  redirect_pc_o;
    logic             flush_o;
    logic [CNT_W-1:0] miss_cnt_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    branch_flush_unit #(.PC_W(PC_W), .CNT_W(CNT_W), .STEP(STEP)) i_branch_flush_unit (
        .clk, .rst_n, .mode_i, .fetch_vld_i, .res_vld_i, .res_taken_i, .res_pred_i,
        .res_pc_i, .res_tgt_i, .nxt_sel_o, .redirect_pc_o, .flush_o, .miss_cnt_o
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        mode_i = 2'd0; fetch_vld_i = 0; res_vld_i = 0; res_taken_i = 0; res_pred_i = 0;
        res_pc_i = BPC; res_tgt_i = BTGT;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        rst_n = 0;
        idle();
        do_reset();
        // R1 reset state
        mode_i = 2'd2; fetch_vld_i = 1;
        #1;
        check("R1 flush", flush_o, 0);
        check("R1 count", miss_cnt_o, 0);
        check("R1 sel", nxt_sel_o, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {mode_i, fetch_vld_i, res_vld_i, res_taken_i, res_pred_i} = VEC[i][8:3];
            #1;
            check($sformatf("R2-5/R11 sel v%0d", i), nxt_sel_o, VEC[i][2:1]);
            @(posedge clk);
            #1;
            check($sformatf("R6/R8/R9 flush v%0d", i), flush_o, VEC[i][0]);
            if (VEC[i][0])
                check($sformatf("R7 pc v%0d", i), redirect_pc_o,
                      VEC[i][4] ? BTGT : BPC + PC_W'(STEP));
        end
        check("R10 count after table", miss_cnt_o, 3);

        // R10 saturation: nine mispredicts, each followed by an idle cycle
        do_reset();
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            mode_i = 2'd1; res_vld_i = 1; res_taken_i = 0; res_pred_i = 1;
            @(negedge clk);
            idle();
            if (k == 5) check("R10 count mid", miss_cnt_o, 6);
        end
        @(negedge clk);
        check("R10 saturated", miss_cnt_o, 7);

        // R1 reset clears counter and history
        @(negedge clk);
        mode_i = 2'd2; res_vld_i = 1; res_taken_i = 1; res_pred_i = 1;
        @(negedge clk);
        idle();
        do_reset();
        mode_i = 2'd2; fetch_vld_i = 1;
        #1;
        check("R1 history cleared", nxt_sel_o, 0);
        check("R1 count cleared", miss_cnt_o, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule